// File: doc/BRIEF.md
# Interlaced TV Encoder Timing Generator

This block drives a byte-wide video link into an external TV encoder, one byte per pixel clock. An upstream source offers luma and chroma bytes through a valid/ready handshake. The block places each accepted byte on a wide display bus and marks it with an active-low data-ready strobe. It also generates an active-low line sync and an active-low field sync. It counts bytes along each line and lines within each field, and it alternates the odd and even fields of an interlaced frame.

The encoder recovers field parity from where the field-sync falling edge sits. For an odd field, which begins a new frame, that edge lands in the same cycle as the line-sync falling edge. For an even field it lands half a line later. Line length, horizontal blanking width, lines per field and field-sync width are static configuration inputs. The interface runs at a nominal 27 MHz, and the logic is sized to close timing about 10% above that.

Top module: `tvenc_timing_gen`

## Requirements
- R1: While reset is low, line sync, field sync and data-ready are high, in_ready is low and the bus byte is 0x10. On the first clock edge after release, the block outputs the first cycle of line 0 of an odd field.
- R2: Each line lasts cfg_line_len cycles. Line sync goes low for exactly one cycle at the first cycle of every line.
- R3: At the start of an odd field, field sync falls in the same cycle as line sync falls, on line 0.
- R4: At the start of an even field, field sync falls at column cfg_line_len/2 of line 0, never in a line-sync-low cycle.
- R5: Field sync stays low for cfg_fsync_len cycles. A value of 0 is treated as 1.
- R6: Fields alternate odd, even, odd and so on. Each field lasts cfg_field_lines lines.
- R7: The active region is columns cfg_hblank to cfg_line_len-1, with cfg_hblank at least 1. in_ready is high only there, so data never coincides with line sync low.
- R8: Inside the active region, byte slots repeat in the order U, Y, V, Y, counted from column cfg_hblank. Even offsets are chroma and odd offsets are luma.
- R9: A byte accepted with in_valid and in_ready high appears on the bus at the next clock edge with data-ready low. Data-ready is low in no other cycle.
- R10: An active slot with no valid input outputs 0x80 for chroma or 0x10 for luma. Outside the active region the byte is 0x10. Data-ready is high in both cases.
- R11: Byte bit 7..0 drives bus bit BYTE_LSB+7..BYTE_LSB (17..10 by default). All other bus bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_line_len | input | COL_W | Total cycles per line (even, at least 4) |
| cfg_hblank | input | COL_W | Blanking cycles at the start of each line (at least 1) |
| cfg_field_lines | input | LINE_W | Lines per field |
| cfg_fsync_len | input | VS_W | Field-sync low width in cycles |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream Y/U/V byte |
| in_ready | output | 1 | Block takes a byte this cycle |
| disp_bus | output | BUS_W | Display data bus |
| line_sync_n | output | 1 | Line sync, active low |
| field_sync_n | output | 1 | Field sync, active low |
| data_rdy_n | output | 1 | Byte valid on bus, active low |

## Verification
A wrong column or line count shows up within one line as a line-sync pulse at the wrong period. It also shifts the U/Y/V/Y blanking pattern and moves the in_ready window. A corrupted field-parity bit shows at the next field boundary: field sync falls at the wrong place relative to line sync, so the coincidence test for odd and even fields flips. A stuck field-sync width counter gives a low pulse of the wrong length at the first field start after reset. The bench therefore compares every output against a cycle model for two full frames per configuration.

// File: rtl/tvt_pkg.sv
package tvt_pkg;
   typedef enum logic [1:0] {
      PH_CB = 2'd0,
      PH_Y0 = 2'd1,
      PH_CR = 2'd2,
      PH_Y1 = 2'd3
   } tvt_phase_e;

   localparam logic [7:0] BLANK_LUMA   = 8'h10;
   localparam logic [7:0] BLANK_CHROMA = 8'h80;
endpackage

// File: rtl/tvt_line_ctr.sv
module tvt_line_ctr #(
   parameter int COL_W  = 12,
   parameter int LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [COL_W-1:0]  cfg_line_len,
   input  logic [LINE_W-1:0] cfg_field_lines,
   output logic [COL_W-1:0]  col_q,
   output logic [LINE_W-1:0] line_q,
   output logic              odd_q
);
   logic last_col, last_line;

   assign last_col  = (col_q  >= cfg_line_len    - COL_W'(1));
   assign last_line = (line_q >= cfg_field_lines - LINE_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q  <= '0;
         line_q <= '0;
         odd_q  <= 1'b1;
      end else if (last_col) begin
         col_q <= '0;
         if (last_line) begin
            line_q <= '0;
            odd_q  <= ~odd_q;
         end else begin
            line_q <= line_q + LINE_W'(1);
         end
      end else begin
         col_q <= col_q + COL_W'(1);
      end
   end
endmodule

// File: rtl/tvt_fsync_gen.sv
module tvt_fsync_gen #(
   parameter int COL_W  = 12,
   parameter int LINE_W = 11,
   parameter int VS_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [COL_W-1:0]  col,
   input  logic [LINE_W-1:0] line,
   input  logic              odd,
   input  logic [COL_W-1:0]  cfg_line_len,
   input  logic [VS_W-1:0]   cfg_fsync_len,
   output logic              fs_now
);
   logic [COL_W-1:0] half_col;
   logic [VS_W-1:0]  width_eff;
   logic [VS_W-1:0]  rem_q;
   logic             start;

   assign half_col  = cfg_line_len >> 1;
   assign width_eff = (cfg_fsync_len == '0) ? VS_W'(1) : cfg_fsync_len;
   assign start     = (line == '0) &&
                      (odd ? (col == '0) : (col == half_col));
   assign fs_now    = start || (rem_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)            rem_q <= '0;
      else if (start)        rem_q <= width_eff - VS_W'(1);
      else if (rem_q != '0)  rem_q <= rem_q - VS_W'(1);
   end
endmodule

// File: rtl/tvt_byte_mux.sv
module tvt_byte_mux
   import tvt_pkg::*;
#(
   parameter int BUS_W    = 18,
   parameter int BYTE_LSB = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  tvt_phase_e       phase,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             ls_now,
   input  logic             fs_now,
   output logic [BUS_W-1:0] bus,
   output logic             ls_n,
   output logic             fs_n,
   output logic             dr_n
);
   logic       take, luma_slot;
   logic [7:0] byte_d, byte_q;

   assign take      = active && in_valid;
   assign luma_slot = (phase == PH_Y0) || (phase == PH_Y1);
   assign byte_d    = take                     ? in_data      :
                      (active && !luma_slot)   ? BLANK_CHROMA : BLANK_LUMA;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_q <= BLANK_LUMA;
         ls_n   <= 1'b1;
         fs_n   <= 1'b1;
         dr_n   <= 1'b1;
      end else begin
         byte_q <= byte_d;
         ls_n   <= ~ls_now;
         fs_n   <= ~fs_now;
         dr_n   <= ~take;
      end
   end

   for (genvar b = 0; b < BUS_W; b++) begin : g_bus
      if (b >= BYTE_LSB && b < BYTE_LSB + 8) begin : g_data
         assign bus[b] = byte_q[b - BYTE_LSB];
      end else begin : g_zero
         assign bus[b] = 1'b0;
      end
   end
endmodule

// File: rtl/tvenc_timing_gen.sv
module tvenc_timing_gen
   import tvt_pkg::*;
#(
   parameter int COL_W    = 12,
   parameter int LINE_W   = 11,
   parameter int VS_W     = 8,
   parameter int BUS_W    = 18,
   parameter int BYTE_LSB = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [COL_W-1:0]  cfg_line_len,
   input  logic [COL_W-1:0]  cfg_hblank,
   input  logic [LINE_W-1:0] cfg_field_lines,
   input  logic [VS_W-1:0]   cfg_fsync_len,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   output logic              in_ready,
   output logic [BUS_W-1:0]  disp_bus,
   output logic              line_sync_n,
   output logic              field_sync_n,
   output logic              data_rdy_n
);
   if (BYTE_LSB < 0 || BYTE_LSB + 8 > BUS_W) begin : g_bad_bus
      $error("tvenc_timing_gen: byte field does not fit the bus");
   end
   if (COL_W < 3 || LINE_W < 1 || VS_W < 1) begin : g_bad_width
      $error("tvenc_timing_gen: counter widths too small");
   end

   logic [COL_W-1:0]  col;
   logic [LINE_W-1:0] line;
   logic              field_odd;
   logic              fs_now, active;
   tvt_phase_e        phase;

   tvt_line_ctr #(.COL_W(COL_W), .LINE_W(LINE_W)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .cfg_line_len(cfg_line_len), .cfg_field_lines(cfg_field_lines),
      .col_q(col), .line_q(line), .odd_q(field_odd)
   );

   tvt_fsync_gen #(.COL_W(COL_W), .LINE_W(LINE_W), .VS_W(VS_W)) u_fs (
      .clk(clk), .rst_n(rst_n),
      .col(col), .line(line), .odd(field_odd),
      .cfg_line_len(cfg_line_len), .cfg_fsync_len(cfg_fsync_len),
      .fs_now(fs_now)
   );

   assign active   = (col >= cfg_hblank);
   assign phase    = tvt_phase_e'(col[1:0] - cfg_hblank[1:0]);
   assign in_ready = active && rst_n;

   tvt_byte_mux #(.BUS_W(BUS_W), .BYTE_LSB(BYTE_LSB)) u_mux (
      .clk(clk), .rst_n(rst_n),
      .active(active), .phase(phase),
      .in_valid(in_valid), .in_data(in_data),
      .ls_now(col == '0), .fs_now(fs_now),
      .bus(disp_bus), .ls_n(line_sync_n), .fs_n(field_sync_n), .dr_n(data_rdy_n)
   );
endmodule

// File: rtl/tvenc_timing_gen_chk.sv
module tvenc_timing_gen_chk #(
   parameter int VS_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_ready,
   input logic            line_sync_n,
   input logic            field_sync_n,
   input logic            data_rdy_n,
   input logic            field_odd,
   input logic [VS_W-1:0] cfg_fsync_len
);
   assert_line_sync_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !line_sync_n |=> line_sync_n);

   // R3 and R4: coincidence of the two falling edges encodes parity
   assert_field_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(field_sync_n) |-> (line_sync_n != field_odd));

   assert_fsync_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(field_sync_n) && (cfg_fsync_len > VS_W'(1))) |=> !field_sync_n);

   assert_data_outside_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !data_rdy_n |-> line_sync_n);

   assert_accept_shows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !data_rdy_n);

   assert_drdy_only_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !data_rdy_n |-> $past(in_valid && in_ready));
endmodule

bind tvenc_timing_gen tvenc_timing_gen_chk #(.VS_W(VS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .line_sync_n(line_sync_n), .field_sync_n(field_sync_n),
   .data_rdy_n(data_rdy_n), .field_odd(field_odd),
   .cfg_fsync_len(cfg_fsync_len)
);

// File: tb/tvenc_timing_gen_tb_top.sv
`timescale 1ns/1ps
module tvenc_timing_gen_tb_top;
   localparam int NCFG = 4;
   // line length, blanking, lines per field, field-sync width, valid pattern
   localparam int         LL [NCFG] = '{16, 12, 20, 10};
   localparam int         HB [NCFG] = '{ 4,  1,  6,  2};
   localparam int         FL [NCFG] = '{ 3,  2,  4,  2};
   localparam int         VL [NCFG] = '{ 2,  1,  0,  3};
   localparam logic [7:0] VP [NCFG] = '{8'hFF, 8'hB6, 8'h00, 8'hEB};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cfg_line_len = 12'd16, cfg_hblank = 12'd4;
   logic [10:0] cfg_field_lines = 11'd3;
   logic [7:0]  cfg_fsync_len = 8'd2;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_ready, line_sync_n, field_sync_n, data_rdy_n;
   logic [17:0] disp_bus;

   always #2 clk = ~clk;

   tvenc_timing_gen dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_line_len(cfg_line_len), .cfg_hblank(cfg_hblank),
      .cfg_field_lines(cfg_field_lines), .cfg_fsync_len(cfg_fsync_len),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .disp_bus(disp_bus), .line_sync_n(line_sync_n),
      .field_sync_n(field_sync_n), .data_rdy_n(data_rdy_n)
   );

   int checks = 0, fails = 0;
   int ll, hb, fl, vl;
   logic [7:0] pat;
   int mcol, mline, mrem, cyc;
   bit modd, have_exp, e_hs, e_vs, e_dr, prev_hs, prev_vs;
   int e_byte;
   int hs_falls, vs_falls, coin, noncoin;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic body();
      bit act_reg, vstart, take, chroma;
      if (have_exp) begin
         chk(line_sync_n == !e_hs, "R2 line sync", line_sync_n, !e_hs);
         chk(field_sync_n == !e_vs, "R5 field sync", field_sync_n, !e_vs);
         chk(data_rdy_n == !e_dr, "R9 data-ready", data_rdy_n, !e_dr);
         chk(disp_bus[17:10] == e_byte[7:0], "R10 bus byte", disp_bus[17:10], e_byte);
         chk(disp_bus[9:0] == 10'd0, "R11 unused bus bits", disp_bus[9:0], 0);
         if (prev_hs && !line_sync_n) hs_falls++;
         if (prev_vs && !field_sync_n) begin
            vs_falls++;
            if (prev_hs && !line_sync_n) coin++; else noncoin++;
         end
      end
      prev_hs = line_sync_n;
      prev_vs = field_sync_n;
      in_valid = pat[cyc % 8];
      in_data  = 8'(cyc * 7 + 3);
      cyc++;
      #1;
      act_reg = (mcol >= hb);
      if (rst_n) chk(in_ready == act_reg, "R7 ready window", in_ready, act_reg);
      vstart = (mline == 0) && (modd ? (mcol == 0) : (mcol == ll / 2));
      take   = act_reg && in_valid;
      chroma = ((mcol - hb) % 2) == 0;
      e_hs   = (mcol == 0);
      e_vs   = vstart || (mrem != 0);
      e_dr   = take;
      e_byte = take ? int'(in_data) : (act_reg && chroma) ? 8'h80 : 8'h10;
      mrem   = vstart ? ((vl == 0 ? 1 : vl) - 1) : (mrem != 0 ? mrem - 1 : 0);
      if (mcol == ll - 1) begin
         mcol = 0;
         if (mline == fl - 1) begin mline = 0; modd = !modd; end
         else mline++;
      end else mcol++;
      have_exp = 1'b1;
   endtask

   task automatic step();
      @(negedge clk);
      body();
   endtask

   task automatic do_reset(input int k);
      rst_n = 1'b0;
      have_exp = 1'b0;
      ll = LL[k]; hb = HB[k]; fl = FL[k]; vl = VL[k]; pat = VP[k];
      cfg_line_len = 12'(ll); cfg_hblank = 12'(hb);
      cfg_field_lines = 11'(fl); cfg_fsync_len = 8'(vl);
      repeat (3) @(negedge clk);
      // R1: idle outputs while reset is held
      chk(line_sync_n && field_sync_n && data_rdy_n, "R1 reset strobes",
          {line_sync_n, field_sync_n, data_rdy_n}, 3'b111);
      chk(in_ready == 1'b0, "R1 reset ready", in_ready, 0);
      chk(disp_bus[17:10] == 8'h10, "R1 reset byte", disp_bus[17:10], 8'h10);
      rst_n = 1'b1;
      mcol = 0; mline = 0; modd = 1'b1; mrem = 0; cyc = 0;
      prev_hs = 1'b1; prev_vs = 1'b1;
      hs_falls = 0; vs_falls = 0; coin = 0; noncoin = 0;
      body();
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int got [4];
      // table walk: two full frames per configuration
      for (int k = 0; k < NCFG; k++) begin
         do_reset(k);
         chk(line_sync_n == 1'b1, "R1 no output before first edge", line_sync_n, 1);
         step();
         chk(!line_sync_n && !field_sync_n, "R1 first cycle odd field start",
             {line_sync_n, field_sync_n}, 0);
         for (int n = 1; n < 4 * FL[k] * LL[k]; n++) step();
         chk(hs_falls == 4 * FL[k], "R2 line count", hs_falls, 4 * FL[k]);
         chk(coin == 2, "R3 odd-field coincident edges", coin, 2);
         chk(noncoin == 2, "R4 even-field offset edges", noncoin, 2);
         chk(vs_falls == 4, "R6 field alternation count", vs_falls, 4);
      end

      // R8: blanking order U,Y,V,Y with no valid input (config 2, blank 6)
      do_reset(2);
      repeat (6) step();
      for (int j = 0; j < 4; j++) begin
         step();
         got[j] = int'(disp_bus[17:10]);
      end
      chk(got[0] == 8'h80 && got[1] == 8'h10 && got[2] == 8'h80 && got[3] == 8'h10,
          "R8 slot order", {got[0][7:0], got[1][7:0], got[2][7:0], got[3][7:0]},
          32'h80108010);

      // R1: reset in mid-field restarts at an odd field
      do_reset(0);
      repeat (37) step();
      do_reset(0);
      step();
      chk(!line_sync_n && !field_sync_n, "R1 restart after mid-run reset",
          {line_sync_n, field_sync_n}, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule